// File: doc/BRIEF.md
# Transmit Idle-Fill Symbol Inserter

This block sits between a parallel transmit holding register and a serializer and produces exactly one 10-bit line symbol on every character clock. When the host asserts its active-low write enable, the character on the input bus is captured at the rising edge and becomes the next symbol. When the host does not write, the input bus is ignored and a K28.5 comma is inserted in that slot, so the line never runs dry.

Two modes are supported. In encoded mode the host supplies a byte, a small stand-in encoder turns it into a 10-bit symbol, and one running-disparity register follows both user symbols and inserted commas. In bypass mode the host supplies finished 10-bit symbols that pass through untouched; no disparity is tracked for them, and the inserted commas only alternate among themselves, restarting at negative disparity each time a fill run follows host data. A separate active-low address-match input drives a registered enable for the flag outputs, modelled as an output-enable signal rather than a tri-state bus. It has no effect on the symbol path.

Top module: `tx_idle_filler`

## Requirements
- R1: While `rst_n` is low, `sym_out` is 10'b0011111010 (K28.5 at negative disparity) and `flag_oe` is 0; that reset symbol counts as sent, so the first symbol after reset is encoded at positive disparity in both modes.
- R2: On a rising edge where `tx_en_n` is 1, `tx_data` is ignored and the next `sym_out` is K28.5: 10'b0011111010 if the disparity in force is negative, 10'b1100000101 if positive; either form flips that disparity.
- R3: In encoded mode (`enc_mode`=1), on a rising edge where `tx_en_n` is 0, the next `sym_out` is the stub code of byte b=`tx_data[7:0]` (`tx_data[9:8]` ignored): if b[7]=0 it is {b[4:0], ~b[4:0]} and leaves disparity unchanged; if b[7]=1 it is {b[3:0], ~b[3:0], 2'b11} at negative and {b[3:0], ~b[3:0], 2'b00} at positive disparity, and flips the disparity.
- R4: In encoded mode a comma inserted after host data is encoded at the disparity left by that data.
- R5: Within any run of consecutive inserted commas, in either mode, each comma uses the opposite form from the one before it.
- R6: In bypass mode (`enc_mode`=0), on a rising edge where `tx_en_n` is 0, the next `sym_out` equals all 10 bits of `tx_data`.
- R7: In bypass mode, the first comma after host data is always 10'b0011111010, whatever the data's disparity or the form of the last comma.
- R8: Symbols sent in bypass mode leave the encoded-mode disparity unchanged; on return to encoded mode it resumes from where encoded mode left it.
- R9: `flag_oe` equals the inverse of `addr_match_n` sampled at the previous rising edge; `addr_match_n` has no effect on `sym_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_n | input | 1 | Active-low write enable for the current character slot |
| enc_mode | input | 1 | 1 = encoded mode with disparity tracking, 0 = pre-encoded bypass |
| tx_data | input | 10 | Host character: byte in bits 7:0 (encoded mode) or full symbol (bypass) |
| addr_match_n | input | 1 | Active-low address match gating the flag output enable |
| sym_out | output | 10 | Line symbol for the serializer, one per clock |
| flag_oe | output | 1 | Output enable for the flag drivers (1 = drive, 0 = high impedance) |

## Verification
The bench walks a stream that crosses every transition between host data and fill in both modes, so a design that used the byte's own disparity instead of the running value, or failed to flip on an unbalanced byte, sends the wrong comma form right after data. A bypass fill run is placed right after a comma that left the local toggle positive, so a design without the restart to negative sends 10'b1100000101 where 10'b0011111010 is due. Leaving bypass after an odd number of commas exposes a design that let bypass symbols disturb the encoded disparity, and a long idle run catches a comma form that sticks instead of alternating. The address-match input is toggled against a fixed symbol expectation, so a design that gated data with it, or did not register the enable, shows up at once.

// File: rtl/fill_pkg.sv
package fill_pkg;

  localparam int SYM_W  = 10;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 5;

  typedef enum logic {RD_NEG = 1'b0, RD_POS = 1'b1} rd_t;

  localparam logic [SYM_W-1:0] COMMA_NEG = 10'b0011111010;
  localparam logic [SYM_W-1:0] COMMA_POS = 10'b1100000101;

  function automatic logic [SYM_W-1:0] comma_sym(input rd_t rd);
    return (rd == RD_NEG) ? COMMA_NEG : COMMA_POS;
  endfunction

  function automatic rd_t rd_flip(input rd_t rd);
    return (rd == RD_NEG) ? RD_POS : RD_NEG;
  endfunction

  // An unbalanced stub code is chosen by the top bit of the byte.
  function automatic logic byte_flips(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1];
  endfunction

  function automatic logic [SYM_W-1:0] stub_encode(input logic [BYTE_W-1:0] b,
                                                   input rd_t rd);
    logic [SYM_W-1:0] s;
    if (!byte_flips(b)) begin
      s = {b[HALF_W-1:0], ~b[HALF_W-1:0]};
    end else if (rd == RD_NEG) begin
      s = {b[3:0], ~b[3:0], 2'b11};
    end else begin
      s = {b[3:0], ~b[3:0], 2'b00};
    end
    return s;
  endfunction

endpackage

// File: rtl/fill_rd_track.sv
module fill_rd_track
  import fill_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_mode,
  input  logic              take_data,
  input  logic [BYTE_W-1:0] data_byte,
  output rd_t               enc_rd,
  output rd_t               byp_rd
);

  rd_t enc_rd_d;
  rd_t byp_rd_d;

  always_comb begin
    enc_rd_d = enc_rd;
    byp_rd_d = byp_rd;
    if (enc_mode) begin
      if (!take_data) begin
        enc_rd_d = rd_flip(enc_rd);
      end else if (byte_flips(data_byte)) begin
        enc_rd_d = rd_flip(enc_rd);
      end
    end else begin
      if (take_data) begin
        byp_rd_d = RD_NEG;
      end else begin
        byp_rd_d = rd_flip(byp_rd);
      end
    end
  end

  // The reset symbol is a negative comma, so both trackers start positive.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_rd <= RD_POS;
      byp_rd <= RD_POS;
    end else begin
      enc_rd <= enc_rd_d;
      byp_rd <= byp_rd_d;
    end
  end

  AST_BYP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!enc_mode && take_data)) |-> (byp_rd == RD_NEG)); // R7

  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!enc_mode)) |-> $stable(enc_rd)); // R8

  AST_ENC_FILL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(enc_mode && !take_data)) |-> (enc_rd != $past(enc_rd))); // R5

endmodule

// File: rtl/fill_sym_sel.sv
module fill_sym_sel
  import fill_pkg::*;
(
  input  logic             tx_en_n,
  input  logic             enc_mode,
  input  logic [SYM_W-1:0] tx_data,
  input  rd_t              enc_rd,
  input  rd_t              byp_rd,
  output logic [SYM_W-1:0] nxt_sym,
  output logic             nxt_fill
);

  rd_t fill_rd;

  always_comb begin
    nxt_fill = tx_en_n;
    fill_rd  = enc_mode ? enc_rd : byp_rd;
    if (tx_en_n) begin
      nxt_sym = comma_sym(fill_rd);
    end else if (enc_mode) begin
      nxt_sym = stub_encode(tx_data[BYTE_W-1:0], enc_rd);
    end else begin
      nxt_sym = tx_data;
    end
  end

endmodule

// File: rtl/fill_flag_gate.sv
module fill_flag_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_match_n,
  output logic flag_oe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_oe <= 1'b0;
    end else begin
      flag_oe <= !addr_match_n;
    end
  end

  AST_FLAG_OE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (flag_oe == !$past(addr_match_n))); // R9

endmodule

// File: rtl/tx_idle_filler.sv
module tx_idle_filler
  import fill_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en_n,
  input  logic             enc_mode,
  input  logic [SYM_W-1:0] tx_data,
  input  logic             addr_match_n,
  output logic [SYM_W-1:0] sym_out,
  output logic             flag_oe
);

  rd_t              enc_rd;
  rd_t              byp_rd;
  logic [SYM_W-1:0] nxt_sym;
  logic             nxt_fill;
  logic             fill_q;
  logic             take_data;

  assign take_data = !tx_en_n;

  fill_rd_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .enc_mode  (enc_mode),
    .take_data (take_data),
    .data_byte (tx_data[BYTE_W-1:0]),
    .enc_rd    (enc_rd),
    .byp_rd    (byp_rd)
  );

  fill_sym_sel u_sel (
    .tx_en_n  (tx_en_n),
    .enc_mode (enc_mode),
    .tx_data  (tx_data),
    .enc_rd   (enc_rd),
    .byp_rd   (byp_rd),
    .nxt_sym  (nxt_sym),
    .nxt_fill (nxt_fill)
  );

  fill_flag_gate u_flag (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_match_n (addr_match_n),
    .flag_oe      (flag_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_out <= COMMA_NEG;
      fill_q  <= 1'b1;
    end else begin
      sym_out <= nxt_sym;
      fill_q  <= nxt_fill;
    end
  end

  AST_FILL_IS_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tx_en_n)) |-> (sym_out == COMMA_NEG || sym_out == COMMA_POS)); // R2

  AST_FILL_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && fill_q && $past(fill_q)) |-> (sym_out != $past(sym_out))); // R5

  AST_BYP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!enc_mode && !tx_en_n)) |-> (sym_out == $past(tx_data))); // R6

  AST_ENC_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(enc_mode)) |-> ($countones(sym_out) >= 4 && $countones(sym_out) <= 6)); // R3

endmodule

// File: tb/tx_idle_filler_test.sv
module tx_idle_filler_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  typedef struct packed {
    logic       en_n;
    logic       enc;
    logic [9:0] data;
    logic       am_n;
    logic [9:0] exp_sym;
    logic       exp_oe;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 10'h3FF, 1'b1, 10'h305, 1'b0},
    '{1'b1, 1'b1, 10'h000, 1'b0, 10'h0FA, 1'b1},
    '{1'b0, 1'b1, 10'h012, 1'b0, 10'h24D, 1'b1},
    '{1'b1, 1'b1, 10'h0FF, 1'b1, 10'h305, 1'b0},
    '{1'b0, 1'b1, 10'h0A5, 1'b1, 10'h16B, 1'b0},
    '{1'b0, 1'b1, 10'h0C3, 1'b0, 10'h0F0, 1'b1},
    '{1'b1, 1'b1, 10'h0C3, 1'b0, 10'h0FA, 1'b1},
    '{1'b1, 1'b0, 10'h000, 1'b1, 10'h305, 1'b0},
    '{1'b0, 1'b0, 10'h2AA, 1'b1, 10'h2AA, 1'b0},
    '{1'b1, 1'b0, 10'h2AA, 1'b0, 10'h0FA, 1'b1},
    '{1'b0, 1'b0, 10'h155, 1'b0, 10'h155, 1'b1},
    '{1'b1, 1'b0, 10'h000, 1'b1, 10'h0FA, 1'b0},
    '{1'b1, 1'b0, 10'h000, 1'b1, 10'h305, 1'b0},
    '{1'b0, 1'b0, 10'h3C0, 1'b0, 10'h3C0, 1'b1},
    '{1'b1, 1'b1, 10'h3C0, 1'b0, 10'h305, 1'b1},
    '{1'b1, 1'b1, 10'h080, 1'b1, 10'h0FA, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en_n = 1'b1;
  logic       enc_mode = 1'b1;
  logic [9:0] tx_data = '0;
  logic       addr_match_n = 1'b1;
  logic [9:0] sym_out;
  logic       flag_oe;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  bit  exp_pos;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_idle_filler uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_en_n      (tx_en_n),
    .enc_mode     (enc_mode),
    .tx_data      (tx_data),
    .addr_match_n (addr_match_n),
    .sym_out      (sym_out),
    .flag_oe      (flag_oe)
  );

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string sym_tag(input int i);
    case (i)
      0, 1, 6, 15: return "R2";
      2, 4, 5:     return "R3";
      3:           return "R4";
      7, 12:       return "R5";
      8, 10, 13:   return "R6";
      9, 11:       return "R7";
      default:     return "R8";
    endcase
  endfunction

  task automatic drive(input logic en_n, input logic enc, input logic [9:0] d, input logic am_n);
    tx_en_n      = en_n;
    enc_mode     = enc;
    tx_data      = d;
    addr_match_n = am_n;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset symbol", sym_out, 10'h0FA);
    chk("R1 reset flag_oe", {9'b0, flag_oe}, 10'h000);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].en_n, VECS[i].enc, VECS[i].data, VECS[i].am_n);
      @(negedge clk);
      chk($sformatf("%s vector %0d", sym_tag(i), i), sym_out, VECS[i].exp_sym);
      chk($sformatf("R9 vector %0d flag_oe", i), {9'b0, flag_oe}, {9'b0, VECS[i].exp_oe});
    end

    // R5: long idle run in encoded mode; disparity is positive after the table.
    exp_pos = 1'b1;
    for (int k = 0; k < 6; k++) begin
      drive(1'b1, 1'b1, 10'(k * 37), k[0]);
      @(negedge clk);
      chk($sformatf("R5 idle run %0d", k), sym_out, exp_pos ? 10'h305 : 10'h0FA);
      exp_pos = !exp_pos;
    end

    // R1: reset in the middle of a stream.
    drive(1'b0, 1'b0, 10'h3FF, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run reset symbol", sym_out, 10'h0FA);
    chk("R1 mid-run reset flag_oe", {9'b0, flag_oe}, 10'h000);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 1'b1, 10'h000, 1'b0);
    @(negedge clk);
    chk("R1 first fill after reset positive", sym_out, 10'h305);
    chk("R9 flag_oe after reset", {9'b0, flag_oe}, 10'h001);

    // R3: unbalanced byte at negative disparity, upper input bits ignored.
    drive(1'b0, 1'b1, 10'h3FF, 1'b1);
    @(negedge clk);
    chk("R3 byte FF at negative", sym_out, 10'h3C3);
    // R4: disparity flipped to positive by that byte.
    drive(1'b1, 1'b1, 10'h000, 1'b1);
    @(negedge clk);
    chk("R4 fill after unbalanced byte", sym_out, 10'h305);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule